// File: doc/BRIEF.md
# Predictor-Steered Instruction Filter Cache

This block sits between an instruction fetch unit and an L1 instruction cache. It holds a tiny direct-mapped filter cache with 16-byte lines and decides for every fetch whether the filter cache is looked up or skipped. Skipping it sends the fetch straight to the L1 request port. The aim is to serve tight loops from the small array and to send fetches that would miss there to the L1 at once, so they do not also pay for a filter lookup.

Steering has two stages. A fetch at the previous address plus four that stays in the same line always goes to the filter cache, because that line was left resident by the fetch before it. Every other fetch counts as a line crossing: a jump, a taken branch, a step into the next line, or the first fetch after reset or flush. For a crossing, a table of 2-bit saturating counters, indexed by the low bits of the target line address, chooses the route. Whenever the L1 supplies an instruction, the whole line is written into the filter cache. A fetch sent to the filter cache that misses there falls back to the L1. The block keeps three event counters so the steering can be checked against a reference model.

The fetch side uses a request/ready pair. The requester holds `fetch_req` and `fetch_pc` stable until `fetch_rdy` pulses for one cycle with the instruction. The L1 side holds `l1_req` and a line address until `l1_rsp_valid` returns the whole line.

Top module: `fcs_filter_steer`

## Requirements
- R1: After reset, `fetch_rdy` and `l1_req` are low, all three event counters read zero, every filter line is invalid, and every prediction counter holds 1.
- R2: A fetch steered to the filter cache whose line is resident has `fetch_rdy` high with the instruction in the cycle after acceptance, and raises no L1 request.
- R3: A fetch whose PC equals the previous fetch PC plus 4 and lies in the same 16-byte line is steered to the filter cache without reading or changing any prediction counter.
- R4: Any other fetch is a crossing. Its route is the filter cache when the prediction counter at index (PC >> 4) mod PRED_ENTRIES holds 2 or more, and the L1 otherwise. The value used is the one held before this fetch updates it.
- R5: At each crossing, that counter goes up by one (saturating at 3) if the target line was resident at acceptance, and down by one (saturating at 0) if it was not.
- R6: A fetch steered to the L1 raises `l1_req` in the cycle after acceptance, with `l1_line_addr` = PC >> 4. The request and address stay stable until `l1_rsp_valid`. `fetch_rdy` follows in the cycle after the response, so the path has no filter lookup in it.
- R7: A fetch steered to the filter cache that misses spends exactly one lookup cycle, then raises `l1_req` as in R6. It never returns data from an invalid line or a line with a different tag.
- R8: On an L1 response the whole line is written at filter index (PC >> 4) mod FC_LINES with the remaining line-address bits as tag. Word k (PC bits [3:2] = k) occupies response bits [32k+31:32k], and that word is the one returned.
- R9: A one-cycle `flush` clears all filter valid bits and the fetch history, so the next fetch is a crossing. Prediction counters keep their values. An L1 fill in the same cycle still writes its line.
- R10: `fc_access_cnt` counts fetches steered to the filter cache, `fc_hit_cnt` counts those that hit, and `l1_access_cnt` counts L1 responses consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all filter lines and fetch history |
| fetch_req | input | 1 | Fetch request, held until `fetch_rdy` |
| fetch_pc | input | PC_W | Byte address of the instruction (word aligned) |
| fetch_rdy | output | 1 | One-cycle pulse: `fetch_data` is valid |
| fetch_data | output | 32 | Fetched instruction |
| l1_req | output | 1 | Line request to the L1 |
| l1_line_addr | output | PC_W-4 | Requested line address (PC >> 4) |
| l1_rsp_valid | input | 1 | L1 line response valid |
| l1_rsp_line | input | LINE_BYTES*8 | Returned line, word 0 in the low bits |
| fc_access_cnt | output | CNT_W | Fetches routed to the filter cache |
| fc_hit_cnt | output | CNT_W | Filter cache hits |
| l1_access_cnt | output | CNT_W | L1 line responses consumed |

## Verification
The bench builds the block with FC_LINES = 4 and PRED_ENTRIES = 4, keeping the 16-byte line. With these values, lines 64 bytes apart evict each other and also share one prediction counter. Short loops can then push a counter to both saturation ends, and conflicting lines produce filter-steered misses (the four-cycle fallback path) after only a few fetches. A reference model in the bench predicts the route, latency, data and counters of each fetch. The model is driven by directed loops, branches inside a line, flushes and an LFSR-driven address walk over sixteen lines.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    localparam int INSTR_W     = 32;
    localparam int INSTR_BYTES = 4;
    localparam int CTR_W       = 2;

    localparam logic [CTR_W-1:0] CTR_INIT = 2'd1;
    localparam logic [CTR_W-1:0] CTR_TAKE = 2'd2;
    localparam logic [CTR_W-1:0] CTR_MAX  = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FC   = 2'd1,
        ST_L1   = 2'd2,
        ST_RESP = 2'd3
    } fsm_e;

    typedef struct packed {
        logic to_fc;
        logic same_line;
        logic crossing;
    } steer_t;

    function automatic logic [CTR_W-1:0] sat_step(input logic [CTR_W-1:0] c,
                                                  input logic up);
        if (up)
            return (c == CTR_MAX) ? c : c + 2'd1;
        else
            return (c == '0) ? c : c - 2'd1;
    endfunction

endpackage

// File: rtl/fcs_line_store.sv
module fcs_line_store #(
    parameter int LINES  = 8,
    parameter int IDX_W  = 3,
    parameter int TAG_W  = 25,
    parameter int LINE_W = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [TAG_W-1:0]  rd_tag,
    output logic              rd_hit,
    output logic [LINE_W-1:0] rd_line,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [LINE_W-1:0] wr_line,
    output logic [LINES-1:0]  valid_vec
);

    logic [LINES-1:0]  valid;
    logic [TAG_W-1:0]  tags  [LINES];
    logic [LINE_W-1:0] lines [LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= '0;
        end else begin
            if (flush)
                valid <= '0;
            if (wr_en)
                valid[wr_idx] <= 1'b1;
        end
    end

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line
            always_ff @(posedge clk) begin
                if (wr_en && wr_idx == IDX_W'(g)) begin
                    tags[g]  <= wr_tag;
                    lines[g] <= wr_line;
                end
            end
        end
    endgenerate

    assign rd_hit    = valid[rd_idx] && (tags[rd_idx] == rd_tag);
    assign rd_line   = lines[rd_idx];
    assign valid_vec = valid;

endmodule

// File: rtl/fcs_pattern_pred.sv
module fcs_pattern_pred
    import fcs_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] look_idx,
    output logic             take_fc,
    input  logic             upd_en,
    input  logic             upd_resident
);

    logic [CTR_W-1:0] ctr [ENTRIES];

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_ctr
            always_ff @(posedge clk) begin
                if (rst)
                    ctr[g] <= CTR_INIT;
                else if (upd_en && look_idx == IDX_W'(g))
                    ctr[g] <= sat_step(ctr[g], upd_resident);
            end
        end
    endgenerate

    assign take_fc = (ctr[look_idx] >= CTR_TAKE);

endmodule

// File: rtl/fcs_steer.sv
module fcs_steer
    import fcs_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int OFF_W = 4
) (
    input  logic            hist_valid,
    input  logic [PC_W-1:0] last_pc,
    input  logic [PC_W-1:0] pc,
    input  logic            pred_take,
    output steer_t          steer
);

    logic seq_next;
    logic line_match;

    assign seq_next   = (pc == last_pc + PC_W'(INSTR_BYTES));
    assign line_match = (pc[PC_W-1:OFF_W] == last_pc[PC_W-1:OFF_W]);

    always_comb begin
        steer.same_line = hist_valid && seq_next && line_match;
        steer.crossing  = !steer.same_line;
        steer.to_fc     = steer.same_line || pred_take;
    end

endmodule

// File: rtl/fcs_filter_steer.sv
module fcs_filter_steer
    import fcs_pkg::*;
#(
    parameter int PC_W         = 32,
    parameter int LINE_BYTES   = 16,
    parameter int FC_LINES     = 8,
    parameter int PRED_ENTRIES = 16,
    parameter int CNT_W        = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    flush,
    input  logic                    fetch_req,
    input  logic [PC_W-1:0]         fetch_pc,
    output logic                    fetch_rdy,
    output logic [INSTR_W-1:0]      fetch_data,
    output logic                    l1_req,
    output logic [PC_W-$clog2(LINE_BYTES)-1:0] l1_line_addr,
    input  logic                    l1_rsp_valid,
    input  logic [LINE_BYTES*8-1:0] l1_rsp_line,
    output logic [CNT_W-1:0]        fc_access_cnt,
    output logic [CNT_W-1:0]        fc_hit_cnt,
    output logic [CNT_W-1:0]        l1_access_cnt
);

    localparam int OFF_W   = $clog2(LINE_BYTES);
    localparam int LINE_W  = LINE_BYTES * 8;
    localparam int WSEL_W  = OFF_W - 2;
    localparam int WPC_W   = PC_W - 2;
    localparam int LADDR_W = PC_W - OFF_W;
    localparam int IDX_W   = $clog2(FC_LINES);
    localparam int TAG_W   = LADDR_W - IDX_W;
    localparam int PIDX_W  = $clog2(PRED_ENTRIES);

    fsm_e               state;
    logic [WPC_W-1:0]   wpc_q;
    logic [PC_W-1:0]    last_pc;
    logic               hist_valid;
    logic               same_line_q;
    logic [INSTR_W-1:0] data_q;

    logic [LADDR_W-1:0] in_line;
    logic [LADDR_W-1:0] q_line;
    logic [IDX_W-1:0]   rd_idx;
    logic [TAG_W-1:0]   rd_tag;
    logic               store_hit;
    logic [LINE_W-1:0]  store_line;
    logic [FC_LINES-1:0] valid_vec;
    logic               fill_en;
    logic               pred_take;
    logic               accept;
    steer_t             steer;
    logic [WSEL_W-1:0]  word_sel;
    logic [INSTR_W-1:0] store_word;
    logic [INSTR_W-1:0] rsp_word;

    assign accept   = (state == ST_IDLE) && fetch_req;
    assign in_line  = fetch_pc[PC_W-1:OFF_W];
    assign q_line   = wpc_q[WPC_W-1:WSEL_W];
    assign word_sel = wpc_q[WSEL_W-1:0];

    // one shared lookup port: incoming PC while idle, captured PC otherwise
    assign rd_idx = (state == ST_IDLE) ? in_line[IDX_W-1:0] : q_line[IDX_W-1:0];
    assign rd_tag = (state == ST_IDLE) ? in_line[LADDR_W-1:IDX_W]
                                       : q_line[LADDR_W-1:IDX_W];

    assign fill_en = (state == ST_L1) && l1_rsp_valid;

    fcs_line_store #(
        .LINES (FC_LINES),
        .IDX_W (IDX_W),
        .TAG_W (TAG_W),
        .LINE_W(LINE_W)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .rd_idx   (rd_idx),
        .rd_tag   (rd_tag),
        .rd_hit   (store_hit),
        .rd_line  (store_line),
        .wr_en    (fill_en),
        .wr_idx   (q_line[IDX_W-1:0]),
        .wr_tag   (q_line[LADDR_W-1:IDX_W]),
        .wr_line  (l1_rsp_line),
        .valid_vec(valid_vec)
    );

    fcs_pattern_pred #(
        .ENTRIES(PRED_ENTRIES),
        .IDX_W  (PIDX_W)
    ) u_pred (
        .clk         (clk),
        .rst         (rst),
        .look_idx    (in_line[PIDX_W-1:0]),
        .take_fc     (pred_take),
        .upd_en      (accept && steer.crossing),
        .upd_resident(store_hit)
    );

    fcs_steer #(
        .PC_W (PC_W),
        .OFF_W(OFF_W)
    ) u_steer (
        .hist_valid(hist_valid),
        .last_pc   (last_pc),
        .pc        (fetch_pc),
        .pred_take (pred_take),
        .steer     (steer)
    );

    assign store_word = store_line[word_sel*INSTR_W +: INSTR_W];
    assign rsp_word   = l1_rsp_line[word_sel*INSTR_W +: INSTR_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= ST_IDLE;
            wpc_q         <= '0;
            last_pc       <= '0;
            hist_valid    <= 1'b0;
            same_line_q   <= 1'b0;
            data_q        <= '0;
            fc_access_cnt <= '0;
            fc_hit_cnt    <= '0;
            l1_access_cnt <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        wpc_q       <= fetch_pc[PC_W-1:2];
                        last_pc     <= fetch_pc;
                        hist_valid  <= 1'b1;
                        same_line_q <= steer.same_line;
                        state       <= steer.to_fc ? ST_FC : ST_L1;
                    end
                end
                ST_FC: begin
                    fc_access_cnt <= fc_access_cnt + 1'b1;
                    if (store_hit) begin
                        fc_hit_cnt <= fc_hit_cnt + 1'b1;
                        state      <= ST_IDLE;
                    end else begin
                        state <= ST_L1;
                    end
                end
                ST_L1: begin
                    if (l1_rsp_valid) begin
                        l1_access_cnt <= l1_access_cnt + 1'b1;
                        data_q        <= rsp_word;
                        state         <= ST_RESP;
                    end
                end
                ST_RESP: begin
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
            if (flush)
                hist_valid <= 1'b0;
        end
    end

    assign fetch_rdy    = ((state == ST_FC) && store_hit) || (state == ST_RESP);
    assign fetch_data   = (state == ST_FC) ? store_word : data_q;
    assign l1_req       = (state == ST_L1);
    assign l1_line_addr = q_line;

endmodule

// File: rtl/fcs_checker.sv
module fcs_checker
    import fcs_pkg::*;
#(
    parameter int LADDR_W = 28,
    parameter int LINES   = 8,
    parameter int CNT_W   = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               flush,
    input fsm_e               state,
    input logic               fetch_rdy,
    input logic               l1_req,
    input logic               l1_rsp_valid,
    input logic [LADDR_W-1:0] l1_line_addr,
    input logic               same_line_q,
    input logic               store_hit,
    input logic [LINES-1:0]   valid_vec,
    input logic [CNT_W-1:0]   fc_access_cnt,
    input logic [CNT_W-1:0]   fc_hit_cnt
);

    AST_RDY_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        fetch_rdy |=> !fetch_rdy); // R2

    AST_SAMELINE_HITS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FC) && same_line_q |-> store_hit); // R3

    AST_L1_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        l1_req && !l1_rsp_valid |=> l1_req && $stable(l1_line_addr)); // R6

    AST_MISS_FALLBACK: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FC) && !store_hit |=> l1_req && !fetch_rdy); // R7

    AST_RSP_RETURNS: assert property (@(posedge clk) disable iff (rst)
        l1_req && l1_rsp_valid |=> fetch_rdy && !l1_req); // R8

    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
        flush && !(l1_req && l1_rsp_valid) |=> valid_vec == '0); // R9

    AST_HIT_IMPLIES_ACCESS: assert property (@(posedge clk) disable iff (rst)
        !$stable(fc_hit_cnt) |-> !$stable(fc_access_cnt)); // R10

endmodule

bind fcs_filter_steer fcs_checker #(
    .LADDR_W(LADDR_W),
    .LINES  (FC_LINES),
    .CNT_W  (CNT_W)
) u_fcs_checker (
    .clk          (clk),
    .rst          (rst),
    .flush        (flush),
    .state        (state),
    .fetch_rdy    (fetch_rdy),
    .l1_req       (l1_req),
    .l1_rsp_valid (l1_rsp_valid),
    .l1_line_addr (l1_line_addr),
    .same_line_q  (same_line_q),
    .store_hit    (store_hit),
    .valid_vec    (valid_vec),
    .fc_access_cnt(fc_access_cnt),
    .fc_hit_cnt   (fc_hit_cnt)
);

// File: tb/fcs_filter_steer_bench.sv
`timescale 1ns/1ps
module fcs_filter_steer_bench;

    localparam int L1_LAT = 2;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         flush = 1'b0;
    logic         fetch_req = 1'b0;
    logic [31:0]  fetch_pc = '0;
    logic         fetch_rdy;
    logic [31:0]  fetch_data;
    logic         l1_req;
    logic [27:0]  l1_line_addr;
    logic         l1_rsp_valid = 1'b0;
    logic [127:0] l1_rsp_line = '0;
    logic [15:0]  fc_access_cnt, fc_hit_cnt, l1_access_cnt;

    int checks = 0;
    int errors = 0;

    // reference model state (4 filter lines, 4 prediction counters)
    bit          mv [4];
    logic [25:0] mt [4];
    logic [1:0]  mc [4];
    bit          hv;
    logic [31:0] lpc;
    int          e_acc, e_hit, e_l1;

    always #5 clk = ~clk;

    fcs_filter_steer #(
        .PC_W(32), .LINE_BYTES(16), .FC_LINES(4), .PRED_ENTRIES(4), .CNT_W(16)
    ) u_fcs_filter_steer (
        .clk(clk), .rst(rst), .flush(flush),
        .fetch_req(fetch_req), .fetch_pc(fetch_pc),
        .fetch_rdy(fetch_rdy), .fetch_data(fetch_data),
        .l1_req(l1_req), .l1_line_addr(l1_line_addr),
        .l1_rsp_valid(l1_rsp_valid), .l1_rsp_line(l1_rsp_line),
        .fc_access_cnt(fc_access_cnt), .fc_hit_cnt(fc_hit_cnt),
        .l1_access_cnt(l1_access_cnt)
    );

    function automatic logic [31:0] instr_at(input logic [31:0] a);
        return {a[31:2], 2'b00} ^ 32'h5A5A_0F0F;
    endfunction

    // behavioural L1: answers L1_LAT cycles after seeing a request
    initial begin
        forever begin
            @(negedge clk);
            if (l1_req) begin
                repeat (L1_LAT - 1) @(negedge clk);
                for (int k = 0; k < 4; k++)
                    l1_rsp_line[32*k +: 32] = instr_at({l1_line_addr, 4'b0000} + 32'(4*k));
                l1_rsp_valid = 1'b1;
                @(negedge clk);
                l1_rsp_valid = 1'b0;
            end
        end
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 4; i++) begin
            mv[i] = 1'b0;
            mt[i] = '0;
            mc[i] = 2'd1;
        end
        hv = 1'b0; lpc = '0; e_acc = 0; e_hit = 0; e_l1 = 0;
    endtask

    task automatic do_fetch(input logic [31:0] pc);
        logic [27:0] ln;
        int idx, lat, exp_lat;
        bit same, res, to_fc;
        string tag;
        logic [31:0] got;
        ln   = pc[31:4];
        idx  = int'(ln[1:0]);
        same = hv && (pc == lpc + 32'd4) && (pc[31:4] == lpc[31:4]);
        res  = mv[idx] && (mt[idx] == ln[27:2]);
        if (same) begin
            to_fc = 1'b1;
        end else begin
            to_fc = (mc[idx] >= 2'd2);
            if (res) mc[idx] = (mc[idx] == 2'd3) ? 2'd3 : mc[idx] + 2'd1;
            else     mc[idx] = (mc[idx] == 2'd0) ? 2'd0 : mc[idx] - 2'd1;
        end
        hv = 1'b1; lpc = pc;
        if (to_fc) begin
            e_acc++;
            if (res) begin e_hit++; exp_lat = 1; end
            else begin e_l1++; exp_lat = 4; end
        end else begin
            e_l1++; exp_lat = 3;
        end
        mv[idx] = 1'b1; mt[idx] = ln[27:2];
        tag = same ? "R3 same-line" : (to_fc ? (res ? "R2 R4 R5 filter-hit" : "R7 R4 R5 fallback")
                                              : "R6 R4 R5 l1-route");

        @(negedge clk);
        fetch_req = 1'b1; fetch_pc = pc;
        lat = 0; got = '0;
        while (1) begin
            @(negedge clk);
            lat++;
            if (fetch_rdy) begin got = fetch_data; break; end
            if (lat > 40) break;
        end
        fetch_req = 1'b0;
        chk($sformatf("%s latency pc=%h", tag, pc), 32'(lat), 32'(exp_lat));
        chk($sformatf("R8 data pc=%h", pc), got, instr_at(pc));
        @(negedge clk);
        chk("R10 fc_access_cnt", 32'(fc_access_cnt), 32'(e_acc));
        chk("R10 fc_hit_cnt", 32'(fc_hit_cnt), 32'(e_hit));
        chk("R10 l1_access_cnt", 32'(l1_access_cnt), 32'(e_l1));
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        for (int i = 0; i < 4; i++) mv[i] = 1'b0;
        hv = 1'b0;
    endtask

    task automatic t_reset();
        model_clear();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 fetch_rdy", 32'(fetch_rdy), 0);
        chk("R1 l1_req", 32'(l1_req), 0);
        chk("R1 fc_access_cnt", 32'(fc_access_cnt), 0);
        chk("R1 fc_hit_cnt", 32'(fc_hit_cnt), 0);
        chk("R1 l1_access_cnt", 32'(l1_access_cnt), 0);
    endtask

    // cold sequential walk: crossing to L1, then same-line filter hits
    task automatic t_cold_walk();
        for (int i = 0; i < 6; i++) do_fetch(32'h100 + 32'(4*i));
    endtask

    // tight loop drives a counter up to saturation (R5)
    task automatic t_loop();
        for (int it = 0; it < 5; it++)
            for (int i = 0; i < 4; i++) do_fetch(32'h100 + 32'(4*i));
    endtask

    // conflicting line 64 bytes away: filter-steered misses (R7)
    task automatic t_conflict();
        do_fetch(32'h140);
        do_fetch(32'h104);
        do_fetch(32'h144);
        do_fetch(32'h100);
    endtask

    // branch inside a line is a crossing (R4)
    task automatic t_branch_in_line();
        do_fetch(32'h200);
        do_fetch(32'h208);
        do_fetch(32'h200);
        do_fetch(32'h20C);
    endtask

    // flush clears lines and history, keeps counters (R9)
    task automatic t_flush();
        for (int i = 0; i < 3; i++) do_fetch(32'h100);
        do_flush();
        do_fetch(32'h100);
        do_fetch(32'h104);
        do_fetch(32'h100);
    endtask

    task automatic t_walk();
        logic [15:0] lfsr = 16'hACE1;
        logic [31:0] pc = 32'h0;
        for (int n = 0; n < 150; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[2:0] < 3'd5) pc = (pc + 32'd4) & 32'hFF;
            else                  pc = {24'h0, lfsr[9:4], 2'b00} ^ {24'h0, lfsr[15:14], 6'h0};
            do_fetch(pc);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all-requirements act=timeout exp=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_cold_walk();
        t_loop();
        t_conflict();
        t_branch_in_line();
        t_flush();
        t_walk();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule